// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block keeps the processor-style status word that follows every ALU step. It takes the two operands and the result that the datapath produced, and an operation class and a width select (byte or word). When the update strobe is high it computes carry, nibble carry, parity, zero, sign and overflow and stores them in a 16-bit flag register on the next clock edge. The add-with-carry and subtract-with-borrow classes take the stored carry as their incoming carry.

Three control flags sit in the same register: direction, interrupt enable and single step. Arithmetic never writes them. Only a command on a separate command input changes them. The same command input can set, clear or invert the carry flag directly.

The design keeps the naming, reset and layout of a controller but has no sequencing state. It is a registered flag word fed by combinational flag logic. Its only "transitions" are update, command and hold, and each one takes effect at the clock edge that samples it.

Top module: `sflag_unit`

## Requirements
- R1: After the active-low reset `rst_n`, the flag word `flags_o` reads 0x0000.
- R2: Bit 0 (carry) holds the carry out of, or the borrow into, the top bit of the selected width: bit 7 when `wide_i`=0, bit 15 when `wide_i`=1. The operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare and 5 logical. Codes 1 and 3 add, or subtract, the stored carry flag as well.
- R3: Bit 4 (nibble carry) holds the carry out of, or the borrow into, bit 3 of the operands.
- R4: Bit 2 (parity) is 1 when `res_i[7:0]` holds an even number of ones. This holds for word operations too.
- R5: Bit 6 (zero) is 1 when the result at the selected width is all zeros. Bit 7 (sign) copies the top bit of the result at the selected width.
- R6: Bit 11 (overflow) is 1 when the signed result of an add or subtract does not fit in the selected width.
- R7: Compare (code 4) sets the flags exactly as subtract (code 2) does.
- R8: Logical (code 5) clears carry, nibble carry and overflow, and updates zero, sign and parity from the result.
- R9: Bits 8 (single step), 9 (interrupt enable) and 10 (direction) change only through `cmd_i`. The codes are 4 set direction, 5 clear direction, 6 set interrupt enable, 7 clear interrupt enable, 8 set step and 9 clear step. Arithmetic updates leave these bits unchanged.
- R10: `cmd_i` code 1 sets the carry flag, code 2 clears it and code 3 inverts it. Codes 0 and 10 to 15 do nothing.
- R11: Bits 1, 3, 5, 12, 13, 14 and 15 of `flags_o` always read 0.
- R12: With `upd_i`=0 and `cmd_i`=0, the flag word holds its value. With `upd_i`=1 and a reserved operation code (6 or 7), the arithmetic flags hold their value.
- R13: A carry command (codes 1 to 3) in the same cycle as `upd_i`=1 is ignored. The arithmetic update, or the hold for a reserved code, decides the carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Arithmetic flag update strobe |
| op_i | input | 3 | Operation class code |
| wide_i | input | 1 | 1 selects word width, 0 selects byte width |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| res_i | input | 16 | Result produced by the ALU |
| cmd_i | input | 4 | Direct flag command |
| flags_o | output | 16 | Flag register |

## Verification
Some behaviour is checked on every cycle by the assertions:
- the reserved bits stay at zero;
- the control flags stay put unless a command that targets them arrives;
- the whole word holds when there is neither a strobe nor a command;
- a logical update leaves carry and overflow cleared;
- parity follows the low result byte.

Other behaviour only the directed scenarios can show:
- carry, nibble carry and overflow for a given operand pair and width;
- add-with-carry and subtract-with-borrow picking up the stored carry;
- compare matching subtract;
- a carry command losing to a simultaneous update.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
    localparam int FLAG_W = 16;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam int CF_B = 0;
    localparam int PF_B = 2;
    localparam int AF_B = 4;
    localparam int ZF_B = 6;
    localparam int SF_B = 7;
    localparam int TF_B = 8;
    localparam int IF_B = 9;
    localparam int DF_B = 10;
    localparam int OF_B = 11;

    localparam logic [FLAG_W-1:0] DEF_MASK = 16'h0FD5;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADC   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SBB   = 3'd3,
        OP_CMP   = 3'd4,
        OP_LOGIC = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        CMD_NONE = 4'd0,
        CMD_SETC = 4'd1,
        CMD_CLRC = 4'd2,
        CMD_INVC = 4'd3,
        CMD_SETD = 4'd4,
        CMD_CLRD = 4'd5,
        CMD_SETI = 4'd6,
        CMD_CLRI = 4'd7,
        CMD_SETT = 4'd8,
        CMD_CLRT = 4'd9
    } cmd_e;
endpackage

// File: rtl/sflag_lane.sv
module sflag_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic         carry_o,
    output logic         ovf_o
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] ext_c;
    logic [W:0] total;

    always_comb begin
        ext_a = {1'b0, a_i};
        ext_b = {1'b0, b_i};
        ext_c = {{W{1'b0}}, cin_i};
        if (sub_i) begin
            total = ext_a - ext_b - ext_c;
            ovf_o = (a_i[W-1] != b_i[W-1]) && (total[W-1] != a_i[W-1]);
        end else begin
            total = ext_a + ext_b + ext_c;
            ovf_o = (a_i[W-1] == b_i[W-1]) && (total[W-1] != a_i[W-1]);
        end
        carry_o = total[W];
    end
endmodule

// File: rtl/sflag_arith.sv
module sflag_arith
    import sflag_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              wide_i,
    output logic              cf_o,
    output logic              af_o,
    output logic              of_o
);
    localparam int LANES = 2;

    logic [LANES-1:0] lane_cf;
    logic [LANES-1:0] lane_of;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        sflag_lane #(.W(LW)) i_lane (
            .a_i     (a_i[LW-1:0]),
            .b_i     (b_i[LW-1:0]),
            .cin_i   (cin_i),
            .sub_i   (sub_i),
            .carry_o (lane_cf[g]),
            .ovf_o   (lane_of[g])
        );
    end

    always_comb begin
        cf_o = wide_i ? lane_cf[1] : lane_cf[0];
        of_o = wide_i ? lane_of[1] : lane_of[0];
        // carry or borrow into bit NIB_W is recovered from the sum bit itself
        af_o = a_i[NIB_W] ^ b_i[NIB_W] ^ res_i[NIB_W];
    end
endmodule

// File: rtl/sflag_result.sv
module sflag_result
    import sflag_pkg::*;
(
    input  logic [DATA_W-1:0] res_i,
    input  logic              wide_i,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o
);
    always_comb begin
        if (wide_i) begin
            zf_o = (res_i == '0);
            sf_o = res_i[DATA_W-1];
        end else begin
            zf_o = (res_i[BYTE_W-1:0] == '0);
            sf_o = res_i[BYTE_W-1];
        end
        pf_o = ~(^res_i[BYTE_W-1:0]);
    end
endmodule

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
    import sflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cmd_i,
    output logic       tf_o,
    output logic       if_o,
    output logic       df_o
);
    cmd_e cmd;
    logic tf_d, if_d, df_d;

    always_comb begin
        cmd  = cmd_e'(cmd_i);
        tf_d = tf_o;
        if_d = if_o;
        df_d = df_o;
        case (cmd)
            CMD_SETD: df_d = 1'b1;
            CMD_CLRD: df_d = 1'b0;
            CMD_SETI: if_d = 1'b1;
            CMD_CLRI: if_d = 1'b0;
            CMD_SETT: tf_d = 1'b1;
            CMD_CLRT: tf_d = 1'b0;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_o <= 1'b0;
            if_o <= 1'b0;
            df_o <= 1'b0;
        end else begin
            tf_o <= tf_d;
            if_o <= if_d;
            df_o <= df_d;
        end
    end

    // R9: control flags move only on a command aimed at them
    a_r9_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i < 4'd4 || cmd_i > 4'd9) |=> $stable({tf_o, if_o, df_o}));
endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
    import sflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_i,
    input  logic [2:0]  op_i,
    input  logic        wide_i,
    input  logic [15:0] opa_i,
    input  logic [15:0] opb_i,
    input  logic [15:0] res_i,
    input  logic [3:0]  cmd_i,
    output logic [15:0] flags_o
);
    op_e  op;
    cmd_e cmd;
    logic is_sub, cin;
    logic n_cf, n_af, n_of, n_zf, n_sf, n_pf;
    logic cf_q, pf_q, af_q, zf_q, sf_q, of_q;
    logic tf_w, if_w, df_w;

    always_comb begin
        op     = op_e'(op_i);
        cmd    = cmd_e'(cmd_i);
        is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        cin    = ((op == OP_ADC) || (op == OP_SBB)) ? cf_q : 1'b0;
    end

    sflag_arith i_arith (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .res_i  (res_i),
        .cin_i  (cin),
        .sub_i  (is_sub),
        .wide_i (wide_i),
        .cf_o   (n_cf),
        .af_o   (n_af),
        .of_o   (n_of)
    );

    sflag_result i_result (
        .res_i  (res_i),
        .wide_i (wide_i),
        .zf_o   (n_zf),
        .sf_o   (n_sf),
        .pf_o   (n_pf)
    );

    sflag_ctrl i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd_i),
        .tf_o  (tf_w),
        .if_o  (if_w),
        .df_o  (df_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q <= 1'b0;
            pf_q <= 1'b0;
            af_q <= 1'b0;
            zf_q <= 1'b0;
            sf_q <= 1'b0;
            of_q <= 1'b0;
        end else if (upd_i) begin
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                    cf_q <= n_cf;
                    af_q <= n_af;
                    of_q <= n_of;
                    pf_q <= n_pf;
                    zf_q <= n_zf;
                    sf_q <= n_sf;
                end
                OP_LOGIC: begin
                    cf_q <= 1'b0;
                    af_q <= 1'b0;
                    of_q <= 1'b0;
                    pf_q <= n_pf;
                    zf_q <= n_zf;
                    sf_q <= n_sf;
                end
                OP_RSV6, OP_RSV7: ;
            endcase
        end else begin
            case (cmd)
                CMD_SETC: cf_q <= 1'b1;
                CMD_CLRC: cf_q <= 1'b0;
                CMD_INVC: cf_q <= ~cf_q;
                default:  ;
            endcase
        end
    end

    always_comb begin
        flags_o       = '0;
        flags_o[CF_B] = cf_q;
        flags_o[PF_B] = pf_q;
        flags_o[AF_B] = af_q;
        flags_o[ZF_B] = zf_q;
        flags_o[SF_B] = sf_q;
        flags_o[TF_B] = tf_w;
        flags_o[IF_B] = if_w;
        flags_o[DF_B] = df_w;
        flags_o[OF_B] = of_q;
    end

    // R11: undefined bits never set
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~DEF_MASK) == 16'h0000);

    // R12: no strobe and no command keeps the word
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && cmd_i == 4'd0) |=> $stable(flags_o));

    // R8: logical update leaves carry and overflow clear
    a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i == 3'd5) |=> (!flags_o[CF_B] && !flags_o[OF_B]));

    // R4: parity follows the low result byte after a valid update
    a_r4_parity_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i <= 3'd5) |=> (flags_o[PF_B] == ~(^$past(res_i[7:0]))));
endmodule

// File: tb/test_sflag_unit.sv
module test_sflag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] a = 16'h0, b = 16'h0, r = 16'h0;
    logic [3:0]  cmd = 4'd0;
    logic [15:0] flags;
    logic [15:0] exp_q = 16'h0;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sflag_unit i_sflag_unit (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .op_i(op), .wide_i(wide),
        .opa_i(a), .opb_i(b), .res_i(r), .cmd_i(cmd), .flags_o(flags)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // ALU result as the datapath would produce it
    function automatic logic [15:0] alu(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y, input logic c);
        logic ci;
        ci = (o == 3'd1 || o == 3'd3) ? c : 1'b0;
        case (o)
            3'd0, 3'd1: alu = x + y + {15'h0, ci};
            3'd2, 3'd3, 3'd4: alu = x - y - {15'h0, ci};
            default: alu = x & y;
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [15:0] old, input logic [2:0] o, input logic w,
                                          input logic [15:0] x, input logic [15:0] y, input logic [15:0] res,
                                          input logic u, input logic [3:0] c);
        logic [15:0] n;
        logic [16:0] s;
        logic [15:0] m;
        logic ci, sub, sx, sy;
        int wd;
        n = old;
        wd = w ? 16 : 8;
        m = w ? 16'hFFFF : 16'h00FF;
        ci = (o == 3'd1 || o == 3'd3) ? old[0] : 1'b0;
        sub = (o == 3'd2 || o == 3'd3 || o == 3'd4);
        if (u && o <= 3'd5) begin
            n[2] = ~(^res[7:0]);
            n[6] = ((res & m) == 16'h0);
            n[7] = res[wd-1];
            if (o == 3'd5) begin
                n[0] = 1'b0; n[4] = 1'b0; n[11] = 1'b0;
            end else begin
                sx = x[wd-1]; sy = y[wd-1];
                if (sub) begin
                    s = {1'b0, x & m} - {1'b0, y & m} - {16'h0, ci};
                    n[4] = ({1'b0, x[3:0]} < ({1'b0, y[3:0]} + {4'h0, ci}));
                    n[11] = (sx != sy) && (s[wd-1] != sx);
                end else begin
                    s = {1'b0, x & m} + {1'b0, y & m} + {16'h0, ci};
                    n[4] = (({1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'h0, ci}) > 5'h0F);
                    n[11] = (sx == sy) && (s[wd-1] != sx);
                end
                n[0] = s[wd];
            end
        end
        if (!u) begin
            if (c == 4'd1) n[0] = 1'b1;
            if (c == 4'd2) n[0] = 1'b0;
            if (c == 4'd3) n[0] = ~old[0];
        end
        if (c == 4'd4) n[10] = 1'b1;
        if (c == 4'd5) n[10] = 1'b0;
        if (c == 4'd6) n[9] = 1'b1;
        if (c == 4'd7) n[9] = 1'b0;
        if (c == 4'd8) n[8] = 1'b1;
        if (c == 4'd9) n[8] = 1'b0;
        return n;
    endfunction

    // one cycle of stimulus, checked at the following falling edge
    task automatic step(input string req, input logic u, input logic [2:0] o, input logic w,
                        input logic [15:0] x, input logic [15:0] y, input logic [3:0] c);
        @(negedge clk);
        upd = u; op = o; wide = w; a = x; b = y; cmd = c;
        r = alu(o, x, y, exp_q[0]);
        exp_q = model(exp_q, o, w, x, y, r, u, c);
        @(negedge clk);
        upd = 1'b0; cmd = 4'd0;
        check(req, flags, exp_q);
    endtask

    task automatic t_reset;
        check("R1 reset value", flags, 16'h0000);
        check("R11 reserved bits", flags & 16'hF02A, 16'h0000);
    endtask

    task automatic t_add;
        step("R2 R3 R6 byte add 7F+01", 1'b1, 3'd0, 1'b0, 16'h007F, 16'h0001, 4'd0);
        check("R6 hand byte overflow", flags, 16'h0890);
        step("R2 R5 byte add FF+01", 1'b1, 3'd0, 1'b0, 16'h12FF, 16'h3401, 4'd0);
        check("R5 hand byte zero", flags, 16'h0055);
        step("R2 word add 8000+8000", 1'b1, 3'd0, 1'b1, 16'h8000, 16'h8000, 4'd0);
        step("R5 word add nonzero", 1'b1, 3'd0, 1'b1, 16'h1234, 16'h4321, 4'd0);
    endtask

    task automatic t_carry_chain;
        step("R10 set carry", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd1);
        step("R2 adc uses carry", 1'b1, 3'd1, 1'b0, 16'h000F, 16'h00F0, 4'd0);
        step("R10 set carry again", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd1);
        step("R2 sbb uses borrow", 1'b1, 3'd3, 1'b1, 16'h0005, 16'h0005, 4'd0);
    endtask

    task automatic t_sub;
        step("R2 R3 word sub 0-1", 1'b1, 3'd2, 1'b1, 16'h0000, 16'h0001, 4'd0);
        check("R2 hand word borrow", flags, 16'h0095);
        step("R6 byte sub 80-01", 1'b1, 3'd2, 1'b0, 16'h0080, 16'h0001, 4'd0);
        step("R7 cmp like sub A", 1'b1, 3'd4, 1'b0, 16'h0080, 16'h0001, 4'd0);
        step("R7 cmp like sub B", 1'b1, 3'd4, 1'b1, 16'h1000, 16'h2001, 4'd0);
    endtask

    task automatic t_logic;
        step("R8 logic clears carry", 1'b1, 3'd5, 1'b1, 16'h0103, 16'hFFFF, 4'd0);
        check("R4 hand parity low byte", flags, 16'h0004);
        step("R4 word parity ignores high", 1'b1, 3'd5, 1'b1, 16'hFF01, 16'hFFFF, 4'd0);
    endtask

    task automatic t_ctrl;
        step("R9 set direction", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd4);
        step("R9 set int enable", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd6);
        step("R9 set step", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd8);
        step("R9 arithmetic keeps control", 1'b1, 3'd2, 1'b1, 16'h0000, 16'h0001, 4'd0);
        check("R9 control bits set", flags & 16'h0700, 16'h0700);
        step("R9 clear int enable", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd7);
        step("R9 clear direction", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd5);
        step("R9 clear step", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd9);
    endtask

    task automatic t_cmc;
        step("R10 clear carry", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd2);
        step("R10 invert carry to 1", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd3);
        check("R10 carry set by invert", flags & 16'h0001, 16'h0001);
        step("R10 invert carry to 0", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd3);
        step("R10 unused command", 1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 4'd12);
    endtask

    task automatic t_conflict;
        step("R13 set carry with update", 1'b1, 3'd0, 1'b0, 16'h0001, 16'h0001, 4'd1);
        check("R13 carry stays clear", flags & 16'h0001, 16'h0000);
        step("R12 reserved op holds", 1'b1, 3'd6, 1'b0, 16'h00FF, 16'h0001, 4'd3);
        step("R12 reserved op 7 holds", 1'b1, 3'd7, 1'b1, 16'h0000, 16'h0000, 4'd0);
        step("R12 idle holds", 1'b0, 3'd0, 1'b1, 16'hFFFF, 16'h0001, 4'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_add;
        t_carry_chain;
        t_sub;
        t_logic;
        t_ctrl;
        t_cmc;
        t_conflict;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule